// File: doc/BRIEF.md
# Programmable Duty Strobe Generator

This block turns a fixed base clock into a periodic strobe for pacing parallel data transfers. A 3-bit divide code `div_code` sets the strobe period to `div_code + 1` base cycles, so a 60 MHz base clock gives rates from 30 MHz down to 7.5 MHz. A 3-bit edge code `edge_code` places the active edge inside each period in steps of one base cycle, and this sets the duty cycle. A polarity bit `pol` chooses whether the active edge of the strobe is rising or falling.

In each period the strobe holds its inactive level for `edge_code` base cycles. It then switches to its active level for the remaining `div_code + 1 - edge_code` cycles. A one-cycle `tick_o` marks the cycle in which the active level begins, and the data path uses it to move a word. A `start` pulse resets the phase so that the first period lines up with the start of a transfer. An illegal code pair holds the strobe at its idle level and raises `cfg_err_o`.

Top module: `duty_strobe`

## Requirements
- R1: While `en`=1 and the codes are legal, the strobe period is `div_code`+1 base cycles. The first cycle after enabling is phase 0, and each later cycle advances the phase by one, wrapping from `div_code` to 0.
- R2: In phases below `edge_code` the strobe shows its inactive level. In phases from `edge_code` up to `div_code` it shows its active level.
- R3: The active level equals `pol` (1: high, so the active edge rises; 0: low, so the active edge falls). The inactive and idle level is `~pol`.
- R4: `tick_o` is 1 for exactly the cycle in which the phase equals `edge_code`. This is the first active cycle of each period, and `tick_o` is 0 in every other cycle.
- R5: When `div_code`=0, `edge_code`=0 or `edge_code`>`div_code`, the strobe shows `~pol`, `tick_o` stays 0 and `cfg_err_o` is 1. All outputs change one cycle after the inputs do.
- R6: With `en`=0 the phase is cleared, the strobe shows `~pol` and `tick_o` is 0. `cfg_err_o` still reports whether the codes are legal.
- R7: A `start` pulse while running makes the following cycle phase 0, whatever the phase was before.
- R8: `rst_n` low drives `strobe_o`, `tick_o` and `cfg_err_o` to 0 at once. After `rst_n` rises, the outputs stay in reset for `SYNC_STAGES` rising edges. Phase 0 falls in the cycle after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Runs the strobe when 1 |
| start | input | 1 | One-cycle pulse that realigns the phase to 0 |
| div_code | input | CODE_W | Period code, period = code + 1 cycles |
| edge_code | input | CODE_W | Phase of the active edge, legal range 1..div_code |
| pol | input | 1 | Active level of the strobe |
| strobe_o | output | 1 | Strobe pin level |
| tick_o | output | 1 | One-cycle marker of the active edge |
| cfg_err_o | output | 1 | Illegal code pair flag |

## Verification
The bench builds the block with its defaults, `CODE_W`=3 and `SYNC_STAGES`=2. A 3-bit code space lets the vector table reach every divide ratio from 2 to 8, the limit cases `edge_code`=1 and `edge_code`=`div_code`, and each class of illegal pair within a few hundred cycles. With two sync stages, the reset release lands on a short, exactly countable cycle, so the bench can check where phase 0 falls after reset.

// File: rtl/dstrb_pkg.sv
package dstrb_pkg;
  // Output phase selected for the strobe pin.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INACT = 2'd1,
    PH_ACT   = 2'd2
  } strobe_phase_e;

  localparam int unsigned DEF_CODE_W      = 3;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/dstrb_rst_sync.sv
module dstrb_rst_sync #(
  parameter int unsigned STAGES = dstrb_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  generate
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_an) begin
        if (!rst_an) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign rst_sn = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_an) begin
        if (!rst_an) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign rst_sn = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dstrb_cfg_check.sv
module dstrb_cfg_check #(
  parameter int unsigned CODE_W = dstrb_pkg::DEF_CODE_W
) (
  input  logic [CODE_W-1:0] div_code,
  input  logic [CODE_W-1:0] edge_code,
  output logic              legal
);
  logic div_zero, edge_zero, edge_over;

  always_comb begin
    div_zero  = (div_code == '0);
    edge_zero = (edge_code == '0);
    edge_over = (edge_code > div_code);
    legal     = !(div_zero || edge_zero || edge_over);
  end
endmodule

// File: rtl/dstrb_phase_cnt.sv
module dstrb_phase_cnt #(
  parameter int unsigned CODE_W = dstrb_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              realign,
  input  logic [CODE_W-1:0] limit,
  output logic              run_n,
  output logic [CODE_W-1:0] cnt_n
);
  logic              run_q;
  logic [CODE_W-1:0] cnt_q;
  logic              at_limit;

  // next state
  always_comb begin
    at_limit = (cnt_q >= limit);
    run_n    = run_req;
    if (!run_req || realign || !run_q || at_limit) cnt_n = '0;
    else                                           cnt_n = cnt_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/dstrb_shaper.sv
module dstrb_shaper
  import dstrb_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_n,
  input  logic [CODE_W-1:0] cnt_n,
  input  logic [CODE_W-1:0] edge_code,
  input  logic              pol,
  output logic              strobe_o,
  output logic              tick_o
);
  strobe_phase_e ph;
  logic          strobe_d, tick_d;
  logic          strobe_q, tick_q;

  // next state
  always_comb begin
    if (!run_n)                 ph = PH_IDLE;
    else if (cnt_n < edge_code) ph = PH_INACT;
    else                        ph = PH_ACT;

    case (ph)
      PH_ACT:  strobe_d = pol;
      default: strobe_d = ~pol;
    endcase
    tick_d = run_n && (cnt_n == edge_code);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      tick_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      tick_q   <= tick_d;
    end
  end

  assign strobe_o = strobe_q;
  assign tick_o   = tick_q;
endmodule

// File: rtl/duty_strobe.sv
module duty_strobe
  import dstrb_pkg::*;
#(
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [CODE_W-1:0] div_code,
  input  logic [CODE_W-1:0] edge_code,
  input  logic              pol,
  output logic              strobe_o,
  output logic              tick_o,
  output logic              cfg_err_o
);
  logic              rst_s;
  logic              legal;
  logic              run_req;
  logic              run_n;
  logic [CODE_W-1:0] cnt_n;
  logic              err_d, err_q;

  dstrb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_s)
  );

  dstrb_cfg_check #(.CODE_W(CODE_W)) u_cfg (
    .div_code  (div_code),
    .edge_code (edge_code),
    .legal     (legal)
  );

  assign run_req = en && legal;

  dstrb_phase_cnt #(.CODE_W(CODE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s),
    .run_req (run_req),
    .realign (start),
    .limit   (div_code),
    .run_n   (run_n),
    .cnt_n   (cnt_n)
  );

  dstrb_shaper #(.CODE_W(CODE_W)) u_shp (
    .clk       (clk),
    .rst_n     (rst_s),
    .run_n     (run_n),
    .cnt_n     (cnt_n),
    .edge_code (edge_code),
    .pol       (pol),
    .strobe_o  (strobe_o),
    .tick_o    (tick_o)
  );

  // next state
  always_comb err_d = !legal;

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cfg_err_o = err_q;
endmodule

// File: rtl/dstrb_sva.sv
module dstrb_sva (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pol,
  input logic strobe_o,
  input logic tick_o,
  input logic cfg_err_o
);
  // R4
  tick_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (strobe_o == $past(pol)));

  // R5
  err_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !tick_o);

  // R5
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (strobe_o == !$past(pol)));

  // R6
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tick_o && (strobe_o == !$past(pol))));
endmodule

bind duty_strobe dstrb_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_s),
  .en        (en),
  .pol       (pol),
  .strobe_o  (strobe_o),
  .tick_o    (tick_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/duty_strobe_tb.sv
`timescale 1ns/1ps
module duty_strobe_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       start = 1'b0;
  logic [2:0] div_code = 3'd7;
  logic [2:0] edge_code = 3'd7;
  logic       pol = 1'b1;
  logic       strobe_o, tick_o, cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  duty_strobe dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start),
    .div_code(div_code), .edge_code(edge_code), .pol(pol),
    .strobe_o(strobe_o), .tick_o(tick_o), .cfg_err_o(cfg_err_o)
  );

  // {div, edge, pol}
  localparam int NV = 14;
  localparam logic [6:0] VEC [NV] = '{
    {3'd1, 3'd1, 1'b1}, {3'd2, 3'd1, 1'b0}, {3'd2, 3'd2, 1'b1},
    {3'd3, 3'd2, 1'b1}, {3'd4, 3'd1, 1'b0}, {3'd5, 3'd3, 1'b1},
    {3'd6, 3'd6, 1'b0}, {3'd7, 3'd7, 1'b1}, {3'd7, 3'd4, 1'b0},
    {3'd0, 3'd0, 1'b1}, {3'd3, 3'd0, 1'b0}, {3'd2, 3'd3, 1'b1},
    {3'd5, 3'd6, 1'b0}, {3'd0, 3'd1, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    #1;
    // R8: outputs in reset
    chk(strobe_o == 0 && tick_o == 0 && cfg_err_o == 0, "R8 reset outputs", {strobe_o, tick_o, cfg_err_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step();

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int f, c, p, per;
      bit bad;
      f = int'(VEC[v][6:4]); c = int'(VEC[v][3:1]); p = int'(VEC[v][0]);
      bad = (f == 0) || (c == 0) || (c > f);
      en = 1'b0; div_code = 3'(f); edge_code = 3'(c); pol = p[0];
      step();
      chk(strobe_o == !p[0] && tick_o == 0, "R6 idle while disabled", strobe_o, !p[0]);
      chk(cfg_err_o == bad, "R5 error flag", cfg_err_o, bad);
      en = 1'b1;
      per = bad ? 8 : f + 1;
      for (int k = 0; k < 2 * per; k++) begin
        int ph;
        bit exp_s, exp_t;
        step();
        ph = k % per;
        if (bad) begin
          exp_s = !p[0]; exp_t = 1'b0;
          chk(strobe_o == exp_s && tick_o == 0 && cfg_err_o == 1, "R5 illegal holds idle", strobe_o, exp_s);
        end else begin
          exp_s = (ph >= c) ? p[0] : !p[0];
          exp_t = (ph == c);
          chk(strobe_o == exp_s, "R2 R3 strobe level by phase", strobe_o, exp_s);
          chk(tick_o == exp_t, "R1 R4 tick position", tick_o, exp_t);
        end
      end
    end

    // R7: realign by start
    en = 1'b0; div_code = 3'd5; edge_code = 3'd3; pol = 1'b1;
    step();
    en = 1'b1;
    for (int k = 0; k < 5; k++) step();
    chk(strobe_o == 1, "R7 pre-start phase 4 active", strobe_o, 1);
    start = 1'b1;
    step();
    start = 1'b0;
    chk(strobe_o == 0 && tick_o == 0, "R7 phase 0 after start", strobe_o, 0);
    step(); step();
    chk(tick_o == 0, "R7 phase 2 no tick", tick_o, 0);
    step();
    chk(tick_o == 1 && strobe_o == 1, "R7 tick at phase 3 after start", tick_o, 1);

    // R6: disable mid-period clears phase
    en = 1'b0;
    step();
    chk(strobe_o == 0 && tick_o == 0, "R6 disabled output idle", strobe_o, 0);
    en = 1'b1;
    step(); step(); step();
    chk(tick_o == 0, "R6 phase 2 after re-enable", tick_o, 0);
    step();
    chk(tick_o == 1, "R6 phase 3 after re-enable", tick_o, 1);

    // R8: asynchronous reset and synchronized release
    div_code = 3'd3; edge_code = 3'd2; pol = 1'b1;
    step(); step();
    rst_n = 1'b0;
    #1;
    chk(strobe_o == 0 && tick_o == 0 && cfg_err_o == 0, "R8 async reset", strobe_o, 0);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk(strobe_o == 0 && tick_o == 0, "R8 held during sync", strobe_o, 0);
    step();
    chk(tick_o == 0, "R8 still in reset at second edge", tick_o, 0);
    step(); // phase 0
    chk(strobe_o == 0 && tick_o == 0, "R8 phase 0 after release", strobe_o, 0);
    step();
    chk(tick_o == 0, "R8 phase 1 after release", tick_o, 0);
    step();
    chk(tick_o == 1 && strobe_o == 1, "R8 tick at phase 2 after release", tick_o, 1);

    finish_run();
  end
endmodule